// File: doc/BRIEF.md
# Sector Erase Acceptance Window Controller

This block sits on the device side of a NOR flash. It decides when a batch of sector erase requests becomes a running erase. It receives command strobes that an upstream bus decoder has already decoded: a sector erase carrying a sector number, a chip erase, an erase suspend, and a catch-all strobe for any other command. The first valid sector erase opens an acceptance window and marks its sector in a selection mask. Each further sector erase that arrives while the window is open adds its sector to the mask and restarts the window at its full length.

When the window runs out with no new sector command, the block raises its "erase begun" status flag. It also emits a one-cycle start pulse, and the accumulated mask is presented next to that pulse. A chip erase skips the window and starts at once. While an erase runs, only erase suspend is honoured; it is acknowledged with a one-cycle pulse. An `erase_done` input from the erase engine ends the run, clears the mask and returns the block to idle.

The window length is given in microseconds and converted to clock cycles from the clock frequency parameter. Sector numbers are bit positions in the mask: sector i is bit i.

Top module: `erase_window_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `erase_begun`, `window_open`, `erase_go`, `chip_go`, `suspend_ack` and `erase_mask` are all zero.
- R2: In idle, a sector erase with index below NUM_SECTORS sets `window_open` in the next cycle and sets bit `idx` of `erase_mask`.
- R3: A valid sector erase while the window is open adds its bit to the mask and restarts the window at full length. A sector that is already selected leaves the mask unchanged but still restarts the window. A command arriving in the last window cycle also restarts it.
- R4: When the window expires, `window_open` falls and `erase_begun` rises in the same cycle. `erase_go` is high for exactly that one cycle, with the accumulated mask on `erase_mask`.
- R5: `erase_begun` becomes visible exactly WIN_CYC cycles after the cycle in which the last valid sector command was sampled. WIN_CYC = max(1, (CLK_FREQ_HZ/1000)*WINDOW_US/1000).
- R6: In idle, a chip erase sets `erase_begun` and pulses `chip_go` for one cycle in the next cycle. It opens no window and leaves `erase_mask` zero.
- R7: While `erase_begun` is 1, sector erase, chip erase and other commands change neither `erase_mask` nor `erase_begun`. An erase suspend produces a one-cycle `suspend_ack` in the next cycle.
- R8: `erase_done` while `erase_begun` is 1 returns the block to idle: `erase_begun` and `erase_mask` are zero in the next cycle. `erase_done` has no effect in idle or while the window is open.
- R9: A sector erase with index NUM_SECTORS or above is ignored. It neither opens nor restarts the window and changes no mask bit.
- R10: While the window is open, chip erase, erase suspend and other commands are ignored. They do not restart or end the window.
- R11: In idle, when a valid sector erase and a chip erase arrive in the same cycle, the sector erase wins: the window opens and `chip_go` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_sector_erase | input | 1 | Decoded sector erase strobe |
| cmd_sector_idx | input | IDX_W | Sector number for the sector erase strobe |
| cmd_chip_erase | input | 1 | Decoded chip erase strobe |
| cmd_suspend | input | 1 | Decoded erase suspend strobe |
| cmd_other | input | 1 | Any other decoded command |
| erase_done | input | 1 | Erase engine reports completion |
| window_open | output | 1 | Acceptance window running |
| erase_begun | output | 1 | Internal erase has begun (status flag) |
| erase_go | output | 1 | One-cycle sector erase start pulse |
| chip_go | output | 1 | One-cycle chip erase start pulse |
| suspend_ack | output | 1 | One-cycle acknowledge of an honoured suspend |
| erase_mask | output | NUM_SECTORS | Selected sectors, bit i is sector i |

## Verification
The window is driven with three patterns: a single sector left to expire, several sectors spaced well inside the window including a repeated one, and a sector command placed on the final cycle before expiry. Together they separate a timer that restarts from one that keeps running, and an off-by-one at the expiry edge from a correct one. Out-of-range indices, foreign commands inside the window, and every command during a running erase show that gating depends on the state. A combined sector and chip strobe confirms the priority in idle.

// File: rtl/ewc_pkg.sv
// Package: shared state encoding for the sector erase window controller.
// Assumes: used only by the ewc_* modules and the top erase_window_ctrl.
package ewc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_WINDOW     = 2'd1,
        ST_SECTOR_RUN = 2'd2,
        ST_CHIP_RUN   = 2'd3
    } ewc_state_t;

endpackage

// File: rtl/ewc_window_timer.sv
// Module: ewc_window_timer
// Counts down the acceptance window. A restart loads the full length in the
// cycle it is asserted; while run is high the count drops by one per cycle.
// at_last flags the final window cycle; the caller decides on expiry.
// Assumes: WIN_CYC >= 1, restart has priority over run.
module ewc_window_timer #(
    parameter int WIN_CYC = 2500,
    parameter int CNT_W   = $clog2(WIN_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic at_last
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WIN_CYC);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    logic [CNT_W-1:0] remaining;

    // Load on restart, otherwise count down while the window runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remaining <= '0;
        end else if (restart) begin
            remaining <= LOAD_VAL;
        end else if (run && remaining != '0) begin
            remaining <= remaining - ONE;
        end
    end

    // Final cycle of the window.
    always_comb begin
        at_last = run && (remaining == ONE);
    end

endmodule

// File: rtl/ewc_sector_mask.sv
// Module: ewc_sector_mask
// Holds one selection bit per sector. An add sets the bit named by idx;
// clear empties the whole mask and wins over add.
// Assumes: idx has already been range checked by the caller.
module ewc_sector_mask #(
    parameter int NUM_SECTORS = 11,
    parameter int IDX_W       = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   clear,
    input  logic                   add,
    input  logic [IDX_W-1:0]       idx,
    output logic [NUM_SECTORS-1:0] mask
);

    for (genvar g = 0; g < NUM_SECTORS; g++) begin : g_bit
        logic hit;

        // Decode this sector's select.
        always_comb begin
            hit = add && (idx == IDX_W'(g));
        end

        // Hold, set on select, drop on clear.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask[g] <= 1'b0;
            end else if (clear) begin
                mask[g] <= 1'b0;
            end else if (hit) begin
                mask[g] <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/ewc_cmd_gate.sv
// Module: ewc_cmd_gate
// Command gating state machine. In idle it opens a window on a valid sector
// command or starts a chip erase. In the window only valid sector commands
// count, and expiry starts the sector erase. While an erase runs only suspend
// is acknowledged, and erase_done returns to idle.
// Assumes: strobes are single-cycle decoded commands; sector beats chip.
module ewc_cmd_gate
    import ewc_pkg::*;
#(
    parameter int NUM_SECTORS = 11,
    parameter int IDX_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_sector_erase,
    input  logic [IDX_W-1:0] cmd_sector_idx,
    input  logic             cmd_chip_erase,
    input  logic             cmd_suspend,
    input  logic             erase_done,
    input  logic             at_last,
    output logic             timer_restart,
    output logic             timer_run,
    output logic             mask_add,
    output logic             mask_clear,
    output logic             window_open,
    output logic             erase_begun,
    output logic             erase_go,
    output logic             chip_go,
    output logic             suspend_ack
);

    ewc_state_t state, state_nxt;
    logic       sector_ok;
    logic       go_nxt, chip_nxt, ack_nxt;

    // Range check of the sector number.
    always_comb begin
        sector_ok = cmd_sector_erase && (32'(cmd_sector_idx) < NUM_SECTORS);
    end

    // Next state and control strobes.
    always_comb begin
        state_nxt     = state;
        timer_restart = 1'b0;
        timer_run     = 1'b0;
        mask_add      = 1'b0;
        mask_clear    = 1'b0;
        go_nxt        = 1'b0;
        chip_nxt      = 1'b0;
        ack_nxt       = 1'b0;
        case (state)
            ST_IDLE: begin
                if (sector_ok) begin
                    timer_restart = 1'b1;
                    mask_add      = 1'b1;
                    state_nxt     = ST_WINDOW;
                end else if (cmd_chip_erase) begin
                    chip_nxt  = 1'b1;
                    state_nxt = ST_CHIP_RUN;
                end
            end
            ST_WINDOW: begin
                timer_run = 1'b1;
                if (sector_ok) begin
                    timer_restart = 1'b1;
                    mask_add      = 1'b1;
                end else if (at_last) begin
                    go_nxt    = 1'b1;
                    state_nxt = ST_SECTOR_RUN;
                end
            end
            ST_SECTOR_RUN, ST_CHIP_RUN: begin
                if (erase_done) begin
                    mask_clear = 1'b1;
                    state_nxt  = ST_IDLE;
                end else if (cmd_suspend) begin
                    ack_nxt = 1'b1;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // State and one-cycle pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            erase_go    <= 1'b0;
            chip_go     <= 1'b0;
            suspend_ack <= 1'b0;
        end else begin
            state       <= state_nxt;
            erase_go    <= go_nxt;
            chip_go     <= chip_nxt;
            suspend_ack <= ack_nxt;
        end
    end

    // Status decoded from the state register.
    always_comb begin
        window_open = (state == ST_WINDOW);
        erase_begun = (state == ST_SECTOR_RUN) || (state == ST_CHIP_RUN);
    end

endmodule

// File: rtl/erase_window_ctrl.sv
// Module: erase_window_ctrl (top)
// Sector erase acceptance window controller. Collects sectors into a mask
// while a restartable window runs, then flags that the erase has begun.
// Assumes: commands arrive already decoded; the erase itself happens outside.
module erase_window_ctrl #(
    parameter int  NUM_SECTORS = 11,
    parameter int  CLK_FREQ_HZ = 50_000_000,
    parameter int  WINDOW_US   = 50,
    localparam int IDX_W       = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_sector_erase,
    input  logic [IDX_W-1:0]       cmd_sector_idx,
    input  logic                   cmd_chip_erase,
    input  logic                   cmd_suspend,
    input  logic                   cmd_other,
    input  logic                   erase_done,
    output logic                   window_open,
    output logic                   erase_begun,
    output logic                   erase_go,
    output logic                   chip_go,
    output logic                   suspend_ack,
    output logic [NUM_SECTORS-1:0] erase_mask
);

    localparam int RAW_CYC = (CLK_FREQ_HZ / 1000) * WINDOW_US / 1000;
    localparam int WIN_CYC = (RAW_CYC < 1) ? 1 : RAW_CYC;

    logic timer_restart, timer_run, at_last;
    logic mask_add, mask_clear;
    logic other_unused;

    // Other commands only matter by being ignored in every state.
    always_comb begin
        other_unused = cmd_other;
    end

    ewc_window_timer #(
        .WIN_CYC (WIN_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (timer_restart),
        .run     (timer_run),
        .at_last (at_last)
    );

    ewc_sector_mask #(
        .NUM_SECTORS (NUM_SECTORS),
        .IDX_W       (IDX_W)
    ) u_mask (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (mask_clear),
        .add   (mask_add),
        .idx   (cmd_sector_idx),
        .mask  (erase_mask)
    );

    ewc_cmd_gate #(
        .NUM_SECTORS (NUM_SECTORS),
        .IDX_W       (IDX_W)
    ) u_gate (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_sector_erase (cmd_sector_erase),
        .cmd_sector_idx   (cmd_sector_idx),
        .cmd_chip_erase   (cmd_chip_erase),
        .cmd_suspend      (cmd_suspend),
        .erase_done       (erase_done),
        .at_last          (at_last),
        .timer_restart    (timer_restart),
        .timer_run        (timer_run),
        .mask_add         (mask_add),
        .mask_clear       (mask_clear),
        .window_open      (window_open),
        .erase_begun      (erase_begun),
        .erase_go         (erase_go),
        .chip_go          (chip_go),
        .suspend_ack      (suspend_ack)
    );

endmodule

// File: rtl/ewc_checker.sv
// Module: ewc_checker
// Port-level temporal checks for erase_window_ctrl, attached by bind.
// Assumes: synchronous active-low reset; every property is disabled in reset.
module ewc_checker #(
    parameter int NUM_SECTORS = 11,
    parameter int IDX_W       = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cmd_sector_erase,
    input logic [IDX_W-1:0]       cmd_sector_idx,
    input logic                   cmd_chip_erase,
    input logic                   cmd_suspend,
    input logic                   erase_done,
    input logic                   window_open,
    input logic                   erase_begun,
    input logic                   erase_go,
    input logic                   chip_go,
    input logic                   suspend_ack,
    input logic [NUM_SECTORS-1:0] erase_mask
);

    AST_GO_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |=> !erase_go); // R4
    AST_GO_WITH_BEGUN: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> (erase_begun && !window_open && erase_mask != '0)); // R4
    AST_WINDOW_NOT_BEGUN: assert property (@(posedge clk) disable iff (!rst_n)
        window_open |-> !erase_begun); // R2
    AST_IDLE_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_open && !erase_begun) |-> (erase_mask == '0)); // R8
    AST_LOCKED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_begun && !erase_done) |=> (erase_begun && $stable(erase_mask))); // R7
    AST_SUSPEND_ACKED: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_begun && !erase_done && cmd_suspend) |=> suspend_ack); // R7
    AST_DONE_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_begun && erase_done) |=> (!erase_begun && erase_mask == '0)); // R8
    AST_CHIP_NO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        chip_go |-> (erase_begun && erase_mask == '0)); // R6
    AST_BAD_IDX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!window_open && !erase_begun && cmd_sector_erase && !cmd_chip_erase
         && 32'(cmd_sector_idx) >= NUM_SECTORS) |=> !window_open); // R9
    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({erase_go, chip_go, suspend_ack}) <= 1); // R7

endmodule

bind erase_window_ctrl ewc_checker #(
    .NUM_SECTORS (NUM_SECTORS),
    .IDX_W       (IDX_W)
) u_ewc_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .cmd_sector_erase (cmd_sector_erase),
    .cmd_sector_idx   (cmd_sector_idx),
    .cmd_chip_erase   (cmd_chip_erase),
    .cmd_suspend      (cmd_suspend),
    .erase_done       (erase_done),
    .window_open      (window_open),
    .erase_begun      (erase_begun),
    .erase_go         (erase_go),
    .chip_go          (chip_go),
    .suspend_ack      (suspend_ack),
    .erase_mask       (erase_mask)
);

// File: tb/erase_window_ctrl_bench.sv
`timescale 1ns/1ps
module erase_window_ctrl_bench;

    localparam int N     = 11;
    localparam int IW    = 4;
    localparam int FREQ  = 1_000_000;
    localparam int WUS   = 50;
    localparam int WIN   = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec = 1'b0, chip = 1'b0, susp = 1'b0, oth = 1'b0, done = 1'b0;
    logic [IW-1:0] idx = '0;
    logic w_open, begun, go, chip_go, ack;
    logic [N-1:0] mask;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    erase_window_ctrl #(
        .NUM_SECTORS (N),
        .CLK_FREQ_HZ (FREQ),
        .WINDOW_US   (WUS)
    ) u_erase_window_ctrl (
        .clk              (clk),
        .rst_n            (rst_n),
        .cmd_sector_erase (sec),
        .cmd_sector_idx   (idx),
        .cmd_chip_erase   (chip),
        .cmd_suspend      (susp),
        .cmd_other        (oth),
        .erase_done       (done),
        .window_open      (w_open),
        .erase_begun      (begun),
        .erase_go         (go),
        .chip_go          (chip_go),
        .suspend_ack      (ack),
        .erase_mask       (mask)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: 0 idle, 1 window, 2 sector run, 3 chip run.
    int m_state = 0;
    int m_since = 0;
    logic [N-1:0] m_mask = '0;
    bit m_go = 0, m_chip = 0, m_ack = 0;

    always @(posedge clk) begin
        m_go = 0; m_chip = 0; m_ack = 0;
        if (!rst_n) begin
            m_state = 0; m_since = 0; m_mask = '0;
        end else begin
            bit valid;
            valid = sec && (int'(idx) < N);
            if (m_state == 0) begin
                if (valid) begin
                    m_state = 1; m_since = 0; m_mask[idx] = 1'b1;
                end else if (chip) begin
                    m_state = 3; m_chip = 1;
                end
            end else if (m_state == 1) begin
                if (valid) begin
                    m_since = 0; m_mask[idx] = 1'b1;
                end else begin
                    m_since++;
                    if (m_since == WIN) begin
                        m_state = 2; m_go = 1;
                    end
                end
            end else begin
                if (done) begin
                    m_state = 0; m_mask = '0;
                end else if (susp) begin
                    m_ack = 1;
                end
            end
        end
    end

    // Compare the model with the design on every cycle, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 window_open", 32'(w_open), 32'(m_state == 1));
            chk("R4 erase_begun", 32'(begun), 32'(m_state >= 2));
            chk("R4 erase_go", 32'(go), 32'(m_go));
            chk("R6 chip_go", 32'(chip_go), 32'(m_chip));
            chk("R7 suspend_ack", 32'(ack), 32'(m_ack));
            chk("R3 erase_mask", 32'(mask), 32'(m_mask));
        end
    end

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cmd(input bit s, input int ix, input bit c, input bit p,
                       input bit o, input bit d);
        sec = s; idx = IW'(ix); chip = c; susp = p; oth = o; done = d;
        @(negedge clk);
        sec = 0; idx = '0; chip = 0; susp = 0; oth = 0; done = 0;
    endtask

    // Count cycles from the last sampled command until erase_begun shows.
    task automatic measure_window(input string tag);
        int n;
        n = 0;
        while (!begun && n < 4 * WIN) begin
            @(negedge clk);
            n++;
        end
        chk(tag, 32'(n), 32'(WIN));
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        idle_cycles(3);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset outputs", 32'({w_open, begun, go, chip_go, ack}), 32'd0);
        chk("R1 reset mask", 32'(mask), 32'd0);

        // R8: done ignored in idle, other/suspend ignored; R9: bad index ignored.
        cmd(0, 0, 0, 1, 1, 1);
        cmd(1, 12, 0, 0, 0, 0);
        chk("R9 bad index in idle", 32'(w_open), 32'd0);

        // R2/R3/R10: several sectors, duplicate, foreign commands in window.
        cmd(1, 3, 0, 0, 0, 0);
        chk("R2 window opens", 32'(w_open), 32'd1);
        chk("R2 mask bit 3", 32'(mask), 32'h008);
        idle_cycles(20);
        cmd(1, 7, 0, 0, 0, 0);
        idle_cycles(40);
        cmd(0, 0, 1, 1, 1, 1);
        cmd(1, 15, 0, 0, 0, 0);
        chk("R10 foreign commands ignored", 32'({w_open, begun}), 32'b10);
        idle_cycles(5);
        cmd(1, 3, 0, 0, 0, 0);
        chk("R3 duplicate keeps mask", 32'(mask), 32'h088);
        measure_window("R5 window after last restart");
        chk("R4 go pulse at expiry", 32'(go), 32'd1);
        chk("R4 mask at expiry", 32'(mask), 32'h088);

        // R7: locked commands, suspend acknowledged.
        cmd(1, 0, 0, 0, 0, 0);
        cmd(0, 0, 1, 0, 1, 0);
        chk("R7 locked mask", 32'(mask), 32'h088);
        cmd(0, 0, 0, 1, 0, 0);
        chk("R7 suspend ack", 32'(ack), 32'd1);
        cmd(0, 0, 0, 0, 0, 1);
        chk("R8 done to idle", 32'({begun, w_open}), 32'd0);
        chk("R8 mask cleared", 32'(mask), 32'd0);

        // R3 boundary: restart on the last window cycle.
        cmd(1, 10, 0, 0, 0, 0);
        idle_cycles(WIN - 1);
        chk("R3 still open before last", 32'(w_open), 32'd1);
        cmd(1, 0, 0, 0, 0, 0);
        chk("R3 last-cycle restart", 32'({w_open, begun}), 32'b10);
        measure_window("R5 window after boundary restart");
        chk("R4 mask highest and lowest", 32'(mask), 32'h401);
        cmd(0, 0, 0, 0, 0, 1);

        // R6: chip erase starts at once.
        cmd(0, 0, 1, 0, 0, 0);
        chk("R6 chip begun", 32'({begun, chip_go, w_open}), 32'b110);
        chk("R6 chip mask", 32'(mask), 32'd0);
        cmd(1, 2, 0, 0, 0, 0);
        chk("R7 sector ignored in chip run", 32'(mask), 32'd0);
        cmd(0, 0, 0, 0, 0, 1);

        // R11: sector wins over chip in idle.
        cmd(1, 5, 1, 0, 0, 0);
        chk("R11 sector priority", 32'({w_open, chip_go, begun}), 32'b100);
        measure_window("R5 window after priority case");
        cmd(0, 0, 0, 0, 0, 1);
        idle_cycles(3);

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule